// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets a bus slave take part in the SMBus alert protocol. The slave raises its alert by pulling a shared open-drain alert line low; several slaves may do so at once, since the line is a wired-AND. When the host sees the line low, it starts a read transfer to the alert response address. This block watches the bus for that transfer. If its own alert is pending, it acknowledges the transfer and returns its own 7-bit slave address one bit at a time.

While it returns that address, the block compares every bit it leaves released (a 1) against the real SDA level. If it sees a 0 there, another slave with a lower address has won. The block then stops driving for the rest of the transfer, keeps its alert, and tries again on the next alert response. A winner clears its pending alert and so releases the alert line.

The slave address is a fixed high part joined to strap pins. The block decodes START and STOP once and gives them to a neighbouring register-access slave engine as single-cycle pulses. SCL and SDA are sampled with the system clock through a synchronizer.

Top module: `sar_responder`

## Requirements
- R1: After reset the block drives neither SDA nor the alert line, and no alert is pending.
- R2: A pulse on `evt_set_i` makes an alert pending. `alert_oe_o` is high in the cycle after the pulse and stays high until the block wins an alert response. A set in the same cycle as a win takes priority.
- R3: The block acknowledges (drives SDA low in the ninth clock) an address byte of 0x19 (address 0001100, R/W = 1) only when an alert is pending, `int_mode_i` = 1 and `act_high_i` = 0. Otherwise it leaves SDA released for the whole transfer.
- R4: After acknowledging, the block sends the byte {DEV_BASE[6:STRAP_W], strap, 0}, MSB first. With the defaults this is 0011 A2 A1 A0 0. The strap value used is the one present at the START, even if the strap pins change later in the transfer.
- R5: If SDA reads 0 at an SCL rise while the block is leaving a 1 bit released, the block loses arbitration. It drives SDA no more in that transfer and its alert stays pending.
- R6: After the eighth bit is sent without a loss, the pending alert is cleared and `alert_oe_o` drops.
- R7: A block that lost arbitration answers the next alert response address again and can win it.
- R8: A read to any other address, and a write to the alert response address, is not acknowledged. SDA is not driven and the pending alert is unchanged.
- R9: `bus_start_o` and `bus_stop_o` give one single-cycle pulse for each START condition (SDA falls while SCL is high) and each STOP condition (SDA rises while SCL is high). They give none for data bits.
- R10: `sda_oe_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | STRAP_W | Strap pins forming the low address bits |
| evt_set_i | input | 1 | Pulse that makes an alert pending |
| int_mode_i | input | 1 | 1 selects interrupt mode |
| act_high_i | input | 1 | 1 selects active-high alert polarity (disables the response) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| alert_oe_o | output | 1 | 1 pulls the shared alert line low |
| bus_start_o | output | 1 | One-cycle pulse when a START is seen |
| bus_stop_o | output | 1 | One-cycle pulse when a STOP is seen |

## Verification
An `evt_set_i` pulse shows on `alert_oe_o` one clock later, and the bench samples it at the next falling edge. Bus results come through a synchronizer and an edge register, about three clocks behind the SCL edge. The bench model keeps every SCL phase at ten clocks and reads SDA in the middle of the high phase, so the acknowledge and each returned bit are settled when sampled. Release of the alert after a win is checked only after the STOP, well after the eighth rising edge. The monitor compares expected and observed items in order, so an item that comes late or is missing leaves a mismatch.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_ACKQ,
      S_ACK,
      S_DATA,
      S_WAIT
   } sar_state_e;

   // response address 0001100 with read bit set
   localparam logic [7:0] RESP_BYTE = 8'b0001_1001;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0:0], d} & {STAGES{1'b1}};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sar_cond.sv
module sar_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start,
   output logic stop
);

   logic scl_p;
   logic sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl;
         sda_p <= sda;
      end
   end

   assign scl_rise = scl & ~scl_p;
   assign scl_fall = ~scl & scl_p;
   assign start    = scl & scl_p & sda_p & ~sda;
   assign stop     = scl & scl_p & ~sda_p & sda;

endmodule

// File: rtl/sar_engine.sv
module sar_engine
   import sar_pkg::*;
#(
   parameter logic [6:0] DEV_BASE = 7'b0011000,
   parameter int         STRAP_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start,
   input  logic               stop,
   input  logic               sda_in,
   input  logic [STRAP_W-1:0] strap,
   input  logic               resp_en,
   input  logic               pending,
   output logic               sda_drv,
   output logic               win
);

   localparam logic [6:0] STRAP_MASK = 7'((1 << STRAP_W) - 1);

   sar_state_e state;
   logic [2:0] cnt;
   logic [7:0] shreg;
   logic [7:0] tx;
   logic [7:0] rx_next;
   logic [6:0] own_addr;
   logic       tx_bit;

   assign rx_next  = {shreg[6:0], sda_in};
   assign own_addr = (DEV_BASE & ~STRAP_MASK) | (7'(strap) & STRAP_MASK);
   assign tx_bit   = tx[3'd7 - cnt];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         tx      <= '0;
         sda_drv <= 1'b0;
         win     <= 1'b0;
      end else begin
         win <= 1'b0;
         if (start) begin
            state   <= S_ADDR;
            cnt     <= '0;
            tx      <= {own_addr, 1'b0};
            sda_drv <= 1'b0;
         end else if (stop) begin
            state   <= S_IDLE;
            sda_drv <= 1'b0;
         end else if (scl_rise) begin
            case (state)
               S_ADDR: begin
                  shreg <= rx_next;
                  cnt   <= cnt + 3'd1;
                  if (cnt == 3'd7) begin
                     if (rx_next == RESP_BYTE && resp_en && pending) state <= S_ACKQ;
                     else                                             state <= S_WAIT;
                  end
               end
               S_DATA: begin
                  cnt <= cnt + 3'd1;
                  if (tx_bit && !sda_in) begin
                     state <= S_WAIT;
                  end else if (cnt == 3'd7) begin
                     win   <= 1'b1;
                     state <= S_WAIT;
                  end
               end
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               S_ACKQ: begin
                  sda_drv <= 1'b1;
                  state   <= S_ACK;
               end
               S_ACK: begin
                  state   <= S_DATA;
                  cnt     <= '0;
                  sda_drv <= ~tx[7];
               end
               S_DATA:  sda_drv <= ~tx_bit;
               default: sda_drv <= 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/sar_responder.sv
module sar_responder #(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_BASE    = 7'b0011000,
   parameter int         STRAP_W     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               evt_set_i,
   input  logic               int_mode_i,
   input  logic               act_high_i,
   output logic               sda_oe_o,
   output logic               alert_oe_o,
   output logic               bus_start_o,
   output logic               bus_stop_o
);

   localparam logic [6:0] LOW_MASK = 7'((1 << STRAP_W) - 1);

   generate
      if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_width
         $error("sar_responder: STRAP_W must lie in 1..6");
      end
      if ((DEV_BASE & LOW_MASK) != 7'd0) begin : g_bad_base
         $error("sar_responder: DEV_BASE low bits must be zero");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sar_responder: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic scl_s;
   logic sda_s;
   logic scl_rise;
   logic scl_fall;
   logic eng_win;
   logic pend;
   logic resp_en;

   sar_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
   );
   sar_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   sar_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_s),
      .sda      (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start    (bus_start_o),
      .stop     (bus_stop_o)
   );

   assign resp_en = int_mode_i & ~act_high_i;

   sar_engine #(.DEV_BASE(DEV_BASE), .STRAP_W(STRAP_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start    (bus_start_o),
      .stop     (bus_stop_o),
      .sda_in   (sda_s),
      .strap    (strap_i),
      .resp_en  (resp_en),
      .pending  (pend),
      .sda_drv  (sda_oe_o),
      .win      (eng_win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend <= 1'b0;
      else if (evt_set_i) pend <= 1'b1;
      else if (eng_win)   pend <= 1'b0;
   end

   assign alert_oe_o = pend;

endmodule

// File: rtl/sar_responder_chk.sv
module sar_responder_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_oe,
   input logic alert_oe,
   input logic evt_set,
   input logic win,
   input logic int_mode,
   input logic act_high,
   input logic bus_start,
   input logic bus_stop
);

   // R1
   a_r1_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!sda_oe && !alert_oe));

   a_r2_set_raises_alert: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set |=> alert_oe);

   a_r3_drive_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (int_mode && !act_high));

   a_r6_clear_only_on_win: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_oe) |-> $past(win));

   a_r9_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_start && bus_stop));

   a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

endmodule

bind sar_responder sar_responder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .sda_oe    (sda_oe_o),
   .alert_oe  (alert_oe_o),
   .evt_set   (evt_set_i),
   .win       (eng_win),
   .int_mode  (int_mode_i),
   .act_high  (act_high_i),
   .bus_start (bus_start_o),
   .bus_stop  (bus_stop_o)
);

// File: tb/test_sar_responder.sv
`timescale 1ns/1ps
module test_sar_responder;

   localparam int H = 10;

   typedef struct {
      string      tag;
      logic [8:0] val;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       oth_drv = 1'b0;
   logic [2:0] strap = 3'd0;
   logic       evt_set = 1'b0;
   logic       int_mode = 1'b1;
   logic       act_high = 1'b0;
   logic       sda_oe;
   logic       alert_oe;
   logic       bus_start;
   logic       bus_stop;
   logic       sda_line;

   logic       oth_en = 1'b0;
   logic [7:0] oth_byte = 8'hFF;
   logic       chg_en = 1'b0;
   logic [2:0] chg_val = 3'd0;

   int tests = 0;
   int fails = 0;
   int starts_seen = 0;
   int stops_seen = 0;
   int starts_sent = 0;
   int bad_moves = 0;
   bit done = 1'b0;

   item_t exp_q[$];
   logic [8:0] obs_q[$];

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe & ~oth_drv;

   sar_responder i_sar_responder (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .strap_i     (strap),
      .evt_set_i   (evt_set),
      .int_mode_i  (int_mode),
      .act_high_i  (act_high),
      .sda_oe_o    (sda_oe),
      .alert_oe_o  (alert_oe),
      .bus_start_o (bus_start),
      .bus_stop_o  (bus_stop)
   );

   logic sda_oe_p = 1'b0;
   always @(posedge clk) begin
      if (bus_start) starts_seen++;
      if (bus_stop)  stops_seen++;
      if (rst_n && scl_m && (sda_oe !== sda_oe_p)) bad_moves++;
      sda_oe_p <= sda_oe;
   end

   // monitor: compares observations with expectations in order
   always @(negedge clk) begin
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
         item_t e;
         logic [8:0] o;
         e = exp_q.pop_front();
         o = obs_q.pop_front();
         tests++;
         if (o !== e.val) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", e.tag, o, e.val);
         end
      end
   end

   task automatic expect_item(input string tag, input logic [8:0] v);
      exp_q.push_back('{tag, v});
   endtask

   task automatic observe(input logic [8:0] v);
      obs_q.push_back(v);
   endtask

   task automatic wait_h(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start_t();
      sda_m = 1'b1; scl_m = 1'b1; wait_h(H);
      sda_m = 1'b0; wait_h(H);
      scl_m = 1'b0; wait_h(2);
      starts_sent++;
   endtask

   task automatic bus_stop_t();
      sda_m = 1'b0; wait_h(H);
      scl_m = 1'b1; wait_h(H);
      sda_m = 1'b1; wait_h(H);
   endtask

   task automatic clk_bit(input logic ob, output logic ib);
      sda_m = ob; wait_h(H);
      scl_m = 1'b1; wait_h(H/2);
      ib = sda_line; wait_h(H/2);
      scl_m = 1'b0;
   endtask

   task automatic txn(input logic [7:0] addr, output logic ack, output logic [7:0] rx);
      logic b;
      logic alive;
      bus_start_t();
      if (chg_en) strap = chg_val;
      for (int i = 0; i < 8; i++) clk_bit(addr[7-i], b);
      oth_drv = oth_en && (addr == 8'h19);
      clk_bit(1'b1, b);
      oth_drv = 1'b0;
      ack = !b;
      rx  = 8'hFF;
      if (ack) begin
         alive = oth_en;
         for (int i = 0; i < 8; i++) begin
            oth_drv = alive & ~oth_byte[7-i];
            clk_bit(1'b1, b);
            if (alive && oth_byte[7-i] && !b) alive = 1'b0;
            rx[7-i] = b;
         end
         oth_drv = 1'b0;
         clk_bit(1'b1, b);
      end
      bus_stop_t();
   endtask

   task automatic pulse_set();
      @(negedge clk) evt_set = 1'b1;
      @(negedge clk) evt_set = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic       ack;
      logic [7:0] rx;
      wait_h(5);
      // R1 reset state
      expect_item("R1 sda_oe", 9'd0);  observe({8'd0, sda_oe});
      expect_item("R1 alert",  9'd0);  observe({8'd0, alert_oe});
      rst_n = 1'b1;
      wait_h(5);

      // R3 no pending: no ack
      txn(8'h19, ack, rx);
      expect_item("R3 no ack without pending", 9'd0); observe({8'd0, ack});

      // R2 set
      pulse_set();
      expect_item("R2 alert next cycle", 9'd1); observe({8'd0, alert_oe});

      // R3/R4/R6 lone responder
      strap = 3'b101;
      txn(8'h19, ack, rx);
      expect_item("R3 ack", 9'd1);           observe({8'd0, ack});
      expect_item("R4 byte 0x3A", 9'h03A);   observe({1'b0, rx});
      expect_item("R6 alert cleared", 9'd0); observe({8'd0, alert_oe});

      // R8 other address and write
      pulse_set();
      strap = 3'b010;
      txn(8'h31, ack, rx);
      expect_item("R8 other addr no ack", 9'd0); observe({8'd0, ack});
      txn(8'h18, ack, rx);
      expect_item("R8 write no ack", 9'd0);      observe({8'd0, ack});
      expect_item("R8 alert kept", 9'd1);        observe({8'd0, alert_oe});

      // R3 mode gating
      int_mode = 1'b0;
      txn(8'h19, ack, rx);
      expect_item("R3 comparator mode no ack", 9'd0); observe({8'd0, ack});
      int_mode = 1'b1; act_high = 1'b1;
      txn(8'h19, ack, rx);
      expect_item("R3 active high no ack", 9'd0);     observe({8'd0, ack});
      act_high = 1'b0;
      expect_item("R3 alert kept", 9'd1);             observe({8'd0, alert_oe});

      // R5 lose to lower address
      strap = 3'b111; oth_en = 1'b1; oth_byte = 8'h30;
      txn(8'h19, ack, rx);
      expect_item("R5 winner byte", 9'h030);   observe({1'b0, rx});
      expect_item("R5 loser alert kept", 9'd1); observe({8'd0, alert_oe});

      // R7 retry alone
      oth_en = 1'b0;
      txn(8'h19, ack, rx);
      expect_item("R7 retry byte 0x3E", 9'h03E); observe({1'b0, rx});
      expect_item("R7 alert cleared", 9'd0);     observe({8'd0, alert_oe});

      // R6 win over higher address
      pulse_set();
      strap = 3'b000; oth_en = 1'b1; oth_byte = 8'h32;
      txn(8'h19, ack, rx);
      expect_item("R6 own byte 0x30", 9'h030);     observe({1'b0, rx});
      expect_item("R6 winner alert clear", 9'd0);  observe({8'd0, alert_oe});
      oth_en = 1'b0;

      // R4 strap sampled at START
      pulse_set();
      strap = 3'b011; chg_en = 1'b1; chg_val = 3'b110;
      txn(8'h19, ack, rx);
      chg_en = 1'b0;
      expect_item("R4 strap at start 0x36", 9'h036); observe({1'b0, rx});

      // R9 / R10
      wait_h(4);
      expect_item("R9 start count", 9'(starts_sent)); observe(9'(starts_seen));
      expect_item("R9 stop count",  9'(starts_sent)); observe(9'(stops_seen));
      expect_item("R10 sda moves with scl high", 9'd0); observe(9'(bad_moves));

      wait_h(4);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule